// File: doc/BRIEF.md
# Two-Wide Fetch Group Controller with Taken-Branch Squash

This block is the fetch-stage controller of a front end that delivers two instructions per cycle. It holds the fetch program counter, presents the aligned two-instruction group address to an instruction memory whose data port is two instructions wide, and asks a branch predictor for one prediction per group. The instructions that came back are registered toward decode together with a per-slot valid mask.

The mask drops slots that lie before the fetch address and slots after a predicted-taken branch. Such a branch ends the group, and the next group starts at the predicted target. A redirect from execute replaces the program counter and kills the group fetched in that cycle. A stall freezes the counter and everything handed to decode.

Instruction memory and predictor are assumed to answer in the same cycle as the address. Their contents, and any recovery beyond the simple redirect, belong to other blocks.

Top module: `fetch_pair_ctl`

## Requirements
- R1: During and right after reset, `dec_valid_o` is all zero and `pc_o` equals the `RESET_PC` parameter (default 0x1000).
- R2: `imem_addr_o` and `pred_addr_o` both equal `pc_o` with its three low bits cleared. One clock after a fetch, `dec_pc_o` holds that aligned address and `dec_insn_o` holds `imem_data_i`, with slot i taken from bits [32i+31:32i].
- R3: With no taken prediction and an aligned `pc_o` (bit 2 clear), the next valid mask is 2'b11 and the next `pc_o` is the aligned address plus 8. The address wraps modulo 2^32.
- R4: When `pc_o` bit 2 is set, slot 0 (mask bit 0) is invalid. Without a taken prediction the next `pc_o` is the aligned address plus 8.
- R5: A taken prediction on slot 0 (`pred_slot_i`=0) from an aligned address gives mask 2'b01, and the next `pc_o` equals `pred_target_i`.
- R6: A taken prediction on slot 1 squashes nothing: mask 2'b11 from an aligned address or 2'b10 from an odd one, and the next `pc_o` equals `pred_target_i`.
- R7: `redir_valid_i` outranks both stall and prediction. On the next clock `pc_o` equals `redir_pc_i` and `dec_valid_o` is all zero.
- R8: With `stall_i` high and no redirect, `pc_o`, `dec_valid_o`, `dec_insn_o` and `dec_pc_o` keep their values across the clock, whatever the prediction inputs are.
- R9: A taken prediction that names a slot before the start slot (slot 0 while `pc_o` bit 2 is set) is ignored. The mask and the next `pc_o` are those of the not-taken case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Freeze fetch and the decode outputs |
| redir_valid_i | input | 1 | Redirect from execute |
| redir_pc_i | input | 32 | Corrected fetch address |
| imem_addr_o | output | 32 | Aligned group address to instruction memory |
| imem_data_i | input | 64 | Two instructions, slot 0 in the low half |
| pred_addr_o | output | 32 | Group address for the predictor lookup |
| pred_taken_i | input | 1 | Predictor says taken |
| pred_slot_i | input | 1 | Slot holding the predicted branch |
| pred_target_i | input | 32 | Predicted target address |
| dec_valid_o | output | 2 | Per-slot valid mask to decode |
| dec_insn_o | output | 64 | Registered instruction pair |
| dec_pc_o | output | 32 | Aligned address of the registered pair |
| pc_o | output | 32 | Current fetch program counter |

## Verification
The assertions check every cycle that a redirect loads its address and clears the mask, that a stall freezes the counter and the mask, and that a fetch ending in the squash, odd-start, last-slot and sequential cases produces the matching mask bit and next address. The bench scenarios cover what needs concrete values: the instruction data and group address reaching decode, wrap at the top of the address space, a prediction ignored because it names a slot before the start slot, and a redirect winning against a stall and a taken prediction in the same cycle.

// File: rtl/fgs_pkg.sv
package fgs_pkg;
   // source of the next fetch address, in priority order
   typedef enum logic [1:0] {
      NPC_FIX  = 2'd0,
      NPC_HOLD = 2'd1,
      NPC_PRED = 2'd2,
      NPC_SEQ  = 2'd3
   } npc_src_e;
endpackage

// File: rtl/fgs_slot_mask.sv
module fgs_slot_mask #(
   parameter int GROUP_N = 2,
   localparam int SLOT_W = (GROUP_N > 1) ? $clog2(GROUP_N) : 1
) (
   input  logic [SLOT_W-1:0]  start_slot,
   input  logic               pred_taken,
   input  logic [SLOT_W-1:0]  pred_slot,
   output logic               taken_eff,
   output logic [GROUP_N-1:0] mask
);
   // a prediction naming a slot before the fetch start is ignored
   assign taken_eff = pred_taken && (pred_slot >= start_slot);

   for (genvar i = 0; i < GROUP_N; i++) begin : g_slot
      logic after_start;
      logic before_cut;
      assign after_start = (SLOT_W'(i) >= start_slot);
      assign before_cut  = !taken_eff || (SLOT_W'(i) <= pred_slot);
      assign mask[i]     = after_start && before_cut;
   end
endmodule

// File: rtl/fgs_next_pc.sv
module fgs_next_pc
   import fgs_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int GRP_BYTES = 8
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] grp_base,
   input  logic              stall,
   input  logic              redir,
   input  logic [ADDR_W-1:0] redir_pc,
   input  logic              taken_eff,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc_next
);
   npc_src_e src;

   always_comb begin
      if (redir)          src = NPC_FIX;
      else if (stall)     src = NPC_HOLD;
      else if (taken_eff) src = NPC_PRED;
      else                src = NPC_SEQ;
   end

   always_comb begin
      unique case (src)
         NPC_FIX:  pc_next = redir_pc;
         NPC_HOLD: pc_next = pc;
         NPC_PRED: pc_next = target;
         default:  pc_next = grp_base + ADDR_W'(GRP_BYTES);
      endcase
   end
endmodule

// File: rtl/fgs_out_stage.sv
module fgs_out_stage #(
   parameter int GROUP_N = 2,
   parameter int INSN_W  = 32,
   parameter int ADDR_W  = 32,
   localparam int DATA_W = GROUP_N * INSN_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stall,
   input  logic               redir,
   input  logic [GROUP_N-1:0] mask,
   input  logic [DATA_W-1:0]  data,
   input  logic [ADDR_W-1:0]  grp_base,
   output logic [GROUP_N-1:0] valid_q,
   output logic [DATA_W-1:0]  insn_q,
   output logic [ADDR_W-1:0]  grp_pc_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= '0;
         insn_q   <= '0;
         grp_pc_q <= '0;
      end else if (redir) begin
         valid_q  <= '0;
         insn_q   <= data;
         grp_pc_q <= grp_base;
      end else if (!stall) begin
         valid_q  <= mask;
         insn_q   <= data;
         grp_pc_q <= grp_base;
      end
   end
endmodule

// File: rtl/fetch_pair_ctl.sv
module fetch_pair_ctl #(
   parameter int          ADDR_W     = 32,
   parameter int          INSN_W     = 32,
   parameter int          GROUP_N    = 2,
   parameter int          INSN_BYTES = 4,
   parameter logic [31:0] RESET_PC   = 32'h0000_1000,
   localparam int SLOT_W    = (GROUP_N > 1) ? $clog2(GROUP_N) : 1,
   localparam int OFF_W     = $clog2(INSN_BYTES),
   localparam int GRP_BYTES = GROUP_N * INSN_BYTES,
   localparam int DATA_W    = GROUP_N * INSN_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stall_i,
   input  logic               redir_valid_i,
   input  logic [ADDR_W-1:0]  redir_pc_i,
   output logic [ADDR_W-1:0]  imem_addr_o,
   input  logic [DATA_W-1:0]  imem_data_i,
   output logic [ADDR_W-1:0]  pred_addr_o,
   input  logic               pred_taken_i,
   input  logic [SLOT_W-1:0]  pred_slot_i,
   input  logic [ADDR_W-1:0]  pred_target_i,
   output logic [GROUP_N-1:0] dec_valid_o,
   output logic [DATA_W-1:0]  dec_insn_o,
   output logic [ADDR_W-1:0]  dec_pc_o,
   output logic [ADDR_W-1:0]  pc_o
);
   // elaboration-time parameter checks
   if (GROUP_N < 2 || (GROUP_N & (GROUP_N - 1)) != 0) begin : g_bad_group
      $error("GROUP_N must be a power of two, at least 2");
   end
   if (INSN_BYTES < 1 || (INSN_BYTES & (INSN_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("INSN_BYTES must be a power of two");
   end
   if (ADDR_W <= OFF_W + SLOT_W || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W out of range");
   end

   logic [ADDR_W-1:0]  pc_q;
   logic [ADDR_W-1:0]  pc_next;
   logic [ADDR_W-1:0]  grp_base;
   logic [SLOT_W-1:0]  start_slot;
   logic               taken_eff;
   logic [GROUP_N-1:0] mask;
   logic               advance;

   assign grp_base    = {pc_q[ADDR_W-1:OFF_W+SLOT_W], {(OFF_W+SLOT_W){1'b0}}};
   assign start_slot  = pc_q[OFF_W+SLOT_W-1:OFF_W];
   assign advance     = !stall_i && !redir_valid_i;
   assign imem_addr_o = grp_base;
   assign pred_addr_o = grp_base;
   assign pc_o        = pc_q;

   fgs_slot_mask #(.GROUP_N(GROUP_N)) u_mask (
      .start_slot (start_slot),
      .pred_taken (pred_taken_i),
      .pred_slot  (pred_slot_i),
      .taken_eff  (taken_eff),
      .mask       (mask)
   );

   fgs_next_pc #(.ADDR_W(ADDR_W), .GRP_BYTES(GRP_BYTES)) u_npc (
      .pc        (pc_q),
      .grp_base  (grp_base),
      .stall     (stall_i),
      .redir     (redir_valid_i),
      .redir_pc  (redir_pc_i),
      .taken_eff (taken_eff),
      .target    (pred_target_i),
      .pc_next   (pc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= ADDR_W'(RESET_PC);
      else        pc_q <= pc_next;
   end

   fgs_out_stage #(.GROUP_N(GROUP_N), .INSN_W(INSN_W), .ADDR_W(ADDR_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .stall    (stall_i),
      .redir    (redir_valid_i),
      .mask     (mask),
      .data     (imem_data_i),
      .grp_base (grp_base),
      .valid_q  (dec_valid_o),
      .insn_q   (dec_insn_o),
      .grp_pc_q (dec_pc_o)
   );

   // ---------------- assertions ----------------
   assert_redirect_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid_i |=> (pc_q == $past(redir_pc_i)) && (dec_valid_o == '0));

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_i && !redir_valid_i) |=> $stable(pc_q) && $stable(dec_valid_o) && $stable(dec_insn_o));

   assert_seq_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !pred_taken_i) |=> pc_q == $past(grp_base) + ADDR_W'(GRP_BYTES));

   assert_odd_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && start_slot != '0) |=> !dec_valid_o[0]);

   assert_squash_slot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && pred_taken_i && pred_slot_i == '0 && start_slot == '0)
      |=> dec_valid_o == GROUP_N'(1));

   assert_taken_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && pred_taken_i && pred_slot_i >= start_slot) |=> pc_q == $past(pred_target_i));

   assert_last_slot_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && pred_taken_i && pred_slot_i == SLOT_W'(GROUP_N - 1)) |=> dec_valid_o[GROUP_N-1]);

   assert_early_slot_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && pred_taken_i && pred_slot_i < start_slot)
      |=> pc_q == $past(grp_base) + ADDR_W'(GRP_BYTES));
endmodule

// File: tb/fetch_pair_ctl_test.sv
module fetch_pair_ctl_test;
   localparam logic [31:0] K = 32'h5A00_00C3;
   localparam int NV = 7;

   // stimulus and expected results: start pc, taken, slot, target, mask, next pc
   localparam logic [31:0] V_PC   [NV] = '{32'h100, 32'h104, 32'h200, 32'h200, 32'h20C, 32'h20C, 32'hFFFF_FFF8};
   localparam logic        V_TK   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
   localparam logic        V_SL   [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
   localparam logic [31:0] V_TGT  [NV] = '{32'h0, 32'h0, 32'h400, 32'h500, 32'h600, 32'h700, 32'h0};
   localparam logic [1:0]  V_MASK [NV] = '{2'b11, 2'b10, 2'b01, 2'b11, 2'b10, 2'b10, 2'b11};
   localparam logic [31:0] V_NEXT [NV] = '{32'h108, 32'h108, 32'h400, 32'h500, 32'h600, 32'h210, 32'h0};
   localparam string       V_REQ  [NV] = '{"R3", "R4", "R5", "R6", "R6", "R9", "R3"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall_i = 1'b0;
   logic        redir_valid_i = 1'b0;
   logic [31:0] redir_pc_i = '0;
   logic [31:0] imem_addr_o;
   logic [63:0] imem_data_i;
   logic [31:0] pred_addr_o;
   logic        pred_taken_i = 1'b0;
   logic        pred_slot_i = 1'b0;
   logic [31:0] pred_target_i = '0;
   logic [1:0]  dec_valid_o;
   logic [63:0] dec_insn_o;
   logic [31:0] dec_pc_o;
   logic [31:0] pc_o;

   int checks = 0;
   int fails = 0;

   always #4 clk = ~clk;

   // instruction memory model: word tagged by its own address
   assign imem_data_i = {(imem_addr_o + 32'd4) ^ K, imem_addr_o ^ K};

   fetch_pair_ctl uut (
      .clk (clk), .rst_n (rst_n), .stall_i (stall_i),
      .redir_valid_i (redir_valid_i), .redir_pc_i (redir_pc_i),
      .imem_addr_o (imem_addr_o), .imem_data_i (imem_data_i),
      .pred_addr_o (pred_addr_o), .pred_taken_i (pred_taken_i),
      .pred_slot_i (pred_slot_i), .pred_target_i (pred_target_i),
      .dec_valid_o (dec_valid_o), .dec_insn_o (dec_insn_o),
      .dec_pc_o (dec_pc_o), .pc_o (pc_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      check("R1 valid in reset", 64'(dec_valid_o), 64'h0);
      check("R1 pc in reset", 64'(pc_o), 64'h1000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pc after reset", 64'(pc_o), 64'h1008);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [31:0] base;
         base = V_PC[i] & 32'hFFFF_FFF8;
         redir_valid_i = 1'b1;
         redir_pc_i    = V_PC[i];
         pred_taken_i  = 1'b0;
         @(negedge clk);
         redir_valid_i = 1'b0;
         check("R7 redirect loads pc", 64'(pc_o), 64'(V_PC[i]));
         check("R7 redirect clears valid", 64'(dec_valid_o), 64'h0);
         check("R2 imem address", 64'(imem_addr_o), 64'(base));
         check("R2 predictor address", 64'(pred_addr_o), 64'(base));
         pred_taken_i  = V_TK[i];
         pred_slot_i   = V_SL[i];
         pred_target_i = V_TGT[i];
         @(negedge clk);
         check({V_REQ[i], " mask"}, 64'(dec_valid_o), 64'(V_MASK[i]));
         check({V_REQ[i], " next pc"}, 64'(pc_o), 64'(V_NEXT[i]));
         check("R2 group pc", 64'(dec_pc_o), 64'(base));
         check("R2 insn pair", dec_insn_o, {(base + 32'd4) ^ K, base ^ K});
         pred_taken_i = 1'b0;
      end

      // R8: stall holds everything despite a taken prediction
      redir_valid_i = 1'b1;
      redir_pc_i    = 32'h100;
      @(negedge clk);
      redir_valid_i = 1'b0;
      @(negedge clk);
      stall_i       = 1'b1;
      pred_taken_i  = 1'b1;
      pred_slot_i   = 1'b0;
      pred_target_i = 32'h900;
      repeat (2) @(negedge clk);
      check("R8 stall holds pc", 64'(pc_o), 64'h108);
      check("R8 stall holds valid", 64'(dec_valid_o), 64'h3);
      check("R8 stall holds insn", dec_insn_o, {32'h104 ^ K, 32'h100 ^ K});
      check("R8 stall holds group pc", 64'(dec_pc_o), 64'h100);

      // R7: redirect wins over stall and a taken prediction
      redir_valid_i = 1'b1;
      redir_pc_i    = 32'h804;
      @(negedge clk);
      check("R7 redirect over stall pc", 64'(pc_o), 64'h804);
      check("R7 redirect over stall valid", 64'(dec_valid_o), 64'h0);
      redir_valid_i = 1'b0;
      stall_i       = 1'b0;
      pred_slot_i   = 1'b1;
      pred_target_i = 32'h40;
      @(negedge clk);
      check("R6 odd start taken last slot mask", 64'(dec_valid_o), 64'h2);
      check("R6 odd start taken last slot pc", 64'(pc_o), 64'h40);
      pred_taken_i = 1'b0;
      @(negedge clk);
      check("R3 sequential after target", 64'(pc_o), 64'h48);
      check("R3 mask after target", 64'(dec_valid_o), 64'h3);

      finish_run();
   end
endmodule